// File: doc/BRIEF.md
# Constant Divider by Counting

This block divides an 8-bit operand by a fixed constant divisor `D` without any arithmetic datapath. A load strobe places the operand in a modulo-256 down counter and clears a modulo-256 up counter that holds the result. A controller then drains the operand one step per clock. It knows only whether the operand is still nonzero, and it pulses the result counter once per group of `D` decrements. The controller never sees the operand's value.

The rounding mode is sampled on the load strobe. In floor mode the result is bumped on the decrement that closes each full group of `D`, so a partial last group adds nothing. In ceiling mode the result is bumped on the first decrement of each group, so any nonzero leftover adds one. Once the operand reaches zero, the controller parks in a hold phase. From then on both enables stay low and `done` is high until the next load.

The controller has two phases:
- **COUNT** tracks the position inside the current group (0 to D-1). On nonzero it asserts the decrement and advances the position, wrapping from D-1 to 0. On zero it asserts nothing and moves to HOLD.
- **HOLD** asserts nothing and stays in HOLD.

From either phase, a load goes to COUNT at position 0. Reset goes to HOLD.

Top module: `cdiv_top`

## Requirements
- R1: A load strobe writes `load_val` into the operand counter, clears the result to 0, starts the controller at group position 0 and captures `round_up`. Both enables are 0 in the load cycle.
- R2: After a load, `dec_en` is 1 on exactly the first V clock cycles, while the operand is nonzero. Each such cycle lowers the operand by one.
- R3: With `round_up` = 0 at load, the final result is floor(V / D).
- R4: With `round_up` = 1 at load, the final result is ceil(V / D), and V = 0 gives 0.
- R5: `inc_en` is asserted only in a cycle where `dec_en` is also asserted. It coincides with the last decrement of a group in floor mode and with the first decrement of a group in ceiling mode.
- R6: While `done` is 1 and no load occurs, `dec_en` and `inc_en` are 0, the result holds its value and `done` stays 1.
- R7: `done` becomes 1 exactly V + 1 clock edges after the load edge: V decrement cycles, then one cycle that sees zero and enters HOLD.
- R8: After synchronous reset, `result` is 0, both enables are 0 and `done` is 1.
- R9: Changing `round_up` after the load has no effect on the result of that run.
- R10: A load during a run abandons it and restarts from the new operand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Load strobe for a new operand |
| load_val | input | 8 | Operand V |
| round_up | input | 1 | 0 = floor, 1 = ceiling; sampled at load |
| result | output | 8 | Quotient W |
| dec_en | output | 1 | Operand decrement enable |
| inc_en | output | 1 | Result increment enable |
| done | output | 1 | Operand drained and controller in HOLD |

## Verification
The bench drives operands of 0, 1, D-1, D, D+1, exact multiples and 255 in both modes. A design with a misplaced increment would show up here as an off-by-one quotient, or as a ceiling result of 1 for a zero operand. The bench toggles `round_up` in the middle of a run, which exposes a controller that reads the live mode instead of the captured one. It also reloads in the middle of a run, which catches a group position or result that is not cleared. Because every output is compared each cycle against a behavioural model, a late `done` or a stray enable after HOLD fails on the cycle it occurs.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;
    typedef enum logic {
        PH_COUNT = 1'b0,
        PH_HOLD  = 1'b1
    } phase_t;

    typedef enum logic {
        RND_FLOOR = 1'b0,
        RND_CEIL  = 1'b1
    } round_t;
endpackage

// File: rtl/cdiv_operand_ctr.sv
module cdiv_operand_ctr #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    input  logic          dec,
    output logic [DW-1:0] count,
    output logic          nonzero
);
    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (dec) begin
            count <= count - 1'b1;
        end
    end

    assign nonzero = |count;
endmodule

// File: rtl/cdiv_result_ctr.sv
module cdiv_result_ctr #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          inc,
    output logic [DW-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (inc) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/cdiv_ctrl.sv
module cdiv_ctrl
    import cdiv_pkg::*;
#(
    parameter int D = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic mode_in,
    input  logic nz,
    output logic dec_en,
    output logic inc_en,
    output logic done
);
    localparam int GW = (D > 1) ? $clog2(D) : 1;
    localparam logic [GW-1:0] LAST = GW'(D - 1);

    phase_t        phase_q, phase_d;
    logic [GW-1:0] grp_q, grp_d;
    round_t        mode_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_HOLD;
            grp_q   <= '0;
            mode_q  <= RND_FLOOR;
        end else if (load) begin
            phase_q <= PH_COUNT;
            grp_q   <= '0;
            mode_q  <= round_t'(mode_in);
        end else begin
            phase_q <= phase_d;
            grp_q   <= grp_d;
        end
    end

    // next state and outputs
    always_comb begin
        phase_d = phase_q;
        grp_d   = grp_q;
        dec_en  = 1'b0;
        inc_en  = 1'b0;
        unique case (phase_q)
            PH_COUNT: begin
                if (nz) begin
                    dec_en = 1'b1;
                    grp_d  = (grp_q == LAST) ? '0 : grp_q + 1'b1;
                    if (mode_q == RND_CEIL) begin
                        inc_en = (grp_q == '0);
                    end else begin
                        inc_en = (grp_q == LAST);
                    end
                end else begin
                    phase_d = PH_HOLD;
                end
            end
            PH_HOLD: begin
                phase_d = PH_HOLD;
            end
            default: phase_d = PH_HOLD;
        endcase
        if (load) begin
            dec_en = 1'b0;
            inc_en = 1'b0;
        end
    end

    assign done = (phase_q == PH_HOLD) && !nz;
endmodule

// File: rtl/cdiv_top.sv
module cdiv_top #(
    parameter int D  = 3,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    input  logic          round_up,
    output logic [DW-1:0] result,
    output logic          dec_en,
    output logic          inc_en,
    output logic          done
);
    logic [DW-1:0] opnd_q;
    logic          opnd_nz;

    cdiv_operand_ctr #(.DW(DW)) u_opnd (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .dec      (dec_en),
        .count    (opnd_q),
        .nonzero  (opnd_nz)
    );

    cdiv_result_ctr #(.DW(DW)) u_res (
        .clk   (clk),
        .rst   (rst),
        .clr   (load),
        .inc   (inc_en),
        .count (result)
    );

    cdiv_ctrl #(.D(D)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .mode_in (round_up),
        .nz      (opnd_nz),
        .dec_en  (dec_en),
        .inc_en  (inc_en),
        .done    (done)
    );
endmodule

// File: rtl/cdiv_chk.sv
module cdiv_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          load,
    input logic [DW-1:0] opnd,
    input logic [DW-1:0] result,
    input logic          dec_en,
    input logic          inc_en,
    input logic          done
);
    // R1
    load_clears_result_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (result == '0));

    // R1
    load_quiet_enables_chk: assert property (@(posedge clk) disable iff (rst)
        load |-> (!dec_en && !inc_en));

    // R2
    dec_needs_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        dec_en |-> (opnd != '0));

    // R2
    dec_steps_one_chk: assert property (@(posedge clk) disable iff (rst)
        (dec_en && !load) |=> (opnd == $past(opnd) - 1'b1));

    // R5
    inc_with_dec_chk: assert property (@(posedge clk) disable iff (rst)
        inc_en |-> dec_en);

    // R6
    done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!dec_en && !inc_en));

    // R6
    done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !load) |=> (done && $stable(result)));
endmodule

bind cdiv_top cdiv_chk #(.DW(DW)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .load   (load),
    .opnd   (opnd_q),
    .result (result),
    .dec_en (dec_en),
    .inc_en (inc_en),
    .done   (done)
);

// File: tb/cdiv_top_bench.sv
`timescale 1ns/1ps
module cdiv_top_bench;
    localparam int D = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       load = 1'b0;
    logic [7:0] load_val = '0;
    logic       round_up = 1'b0;
    logic [7:0] result;
    logic       dec_en, inc_en, done;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    int m_op, m_res, m_grp;
    bit m_hold, m_mode;
    int since_load;

    always #4 clk = ~clk;

    cdiv_top #(.D(D), .DW(8)) u_cdiv_top (
        .clk(clk), .rst(rst), .load(load), .load_val(load_val),
        .round_up(round_up), .result(result), .dec_en(dec_en),
        .inc_en(inc_en), .done(done)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
        end
    endtask

    // One clock: drive inputs, compare outputs with the model, advance the model.
    task automatic step(input bit ld, input int v, input bit md);
        bit e_dec, e_inc, e_done, z;
        @(negedge clk);
        load = ld; load_val = v[7:0]; round_up = md;
        #1;
        z = (m_op != 0);
        e_dec = 0; e_inc = 0;
        if (!ld && !m_hold && z) begin
            e_dec = 1;
            e_inc = m_mode ? (m_grp == 0) : (m_grp == D - 1);
        end
        e_done = m_hold && !z;
        check("R2 dec_en", int'(dec_en), int'(e_dec));
        check("R5 inc_en", int'(inc_en), int'(e_inc));
        check("R7 done", int'(done), int'(e_done));
        check("R6 result", int'(result), m_res);
        @(posedge clk);
        if (ld) begin
            m_op = v; m_res = 0; m_grp = 0; m_hold = 0; m_mode = md;
            since_load = 0;
        end else begin
            since_load++;
            if (!m_hold) begin
                if (m_op != 0) begin
                    if (e_inc) m_res = (m_res + 1) % 256;
                    m_op--;
                    m_grp = (m_grp == D - 1) ? 0 : m_grp + 1;
                end else begin
                    m_hold = 1;
                end
            end
        end
    endtask

    // Load V, run to completion, check quotient and done timing.
    task automatic run(input int v, input bit md, input bit wiggle);
        int exp_w, first_done;
        step(1, v, md);
        #1;
        check("R1 result cleared", int'(result), 0);
        first_done = -1;
        for (int i = 0; i < v + 4; i++) begin
            step(0, 0, wiggle ? bit'(~md ^ i[0]) : md);
            #1;
            if (done && first_done < 0) first_done = since_load;
        end
        exp_w = md ? (v + D - 1) / D : v / D;
        if (md) check("R4 ceil quotient", int'(result), exp_w);
        else    check("R3 floor quotient", int'(result), exp_w);
        if (wiggle) check("R9 mode ignored", int'(result), exp_w);
        check("R7 done latency", first_done, v + 1);
    endtask

    initial begin
        m_op = 0; m_res = 0; m_grp = 0; m_hold = 1; m_mode = 0; since_load = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R8
        check("R8 reset result", int'(result), 0);
        check("R8 reset done", int'(done), 1);
        check("R8 reset dec_en", int'(dec_en), 0);
        check("R8 reset inc_en", int'(inc_en), 0);

        begin
            int vals[11] = '{0, 1, 2, 3, 4, 5, 6, 7, 9, 254, 255};
            foreach (vals[k]) begin
                run(vals[k], 1'b0, 1'b0);
                run(vals[k], 1'b1, 1'b0);
            end
        end
        // R9: mode input toggles after load
        run(8, 1'b0, 1'b1);
        run(8, 1'b1, 1'b1);
        run(100, 1'b1, 1'b1);

        // R10: reload mid-run
        step(1, 200, 1'b0);
        repeat (10) step(0, 0, 1'b0);
        run(10, 1'b1, 1'b0);
        step(1, 50, 1'b1);
        repeat (4) step(0, 0, 1'b1);
        run(11, 1'b0, 1'b0);
        check("R10 restart quotient", int'(result), 11 / D);

        // R6: long idle after done
        repeat (20) step(0, 0, 1'b1);
        check("R6 held result", int'(result), 11 / D);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule